// File: doc/BRIEF.md
# Converter Protection Fault Supervisor

This block is the digital half of the protection logic in a step-down converter controller. It takes comparator results as single-bit inputs and decides when the converter may switch. The inputs are: current sense above the output, feedback below the undervoltage level, the two temperature flags for the rising limit and the hysteresis release, the enable level, and the supply power-on status. Each comparator bit passes through a two-flop synchronizer. A fault counts only after it persists without a break. Overcurrent must last longer than 10 µs and undervoltage longer than 2 µs. Both limits are converted to clock cycles from a clock-frequency parameter by rounding up.

A persistent overcurrent or undervoltage latches the converter off. PWM enable, both gate-drive enables and power-good all drop, and a two-bit cause code records which fault came first. The latch releases only when enable drops or the supply status falls. Over-temperature behaves differently: it only suspends the two gate drives. It does not latch, does not touch power-good, and ends when the cool flag reports the hysteresis release.

Top module: `prot_supervisor`

## Requirements
- R1: An overcurrent fault latches only when the synchronized overcurrent input has been high on more than OC_LIM consecutive clock edges. At the 50 MHz default, OC_LIM = ceil(10 µs × CLK_HZ) = 500: 500 edges do not trip and 501 edges do. A single low edge restarts the count.
- R2: An undervoltage fault latches only when the synchronized undervoltage input has been high on more than UV_LIM consecutive edges. UV_LIM = ceil(2 µs × CLK_HZ), which is 100 at the default.
- R3: While a fault is latched, `pwm_en`, `hs_gate_en`, `ls_gate_en` and `pgood` are low. They stay low after the fault condition goes away.
- R4: Enable low clears the latched fault, sets the cause code to 0 and ends thermal suspend. When enable returns high, all outputs come back high.
- R5: Supply status low clears the latched fault and the cause code in the same way as R4.
- R6: While `ot_hot` is high, the block enters thermal suspend. Both gate enables go low, while `pwm_en` and `pgood` stay high and no fault is latched.
- R7: Thermal suspend persists after `ot_hot` falls. It ends when `ot_cool` goes high, or when enable goes low.
- R8: Fault detection keeps running in thermal suspend. An undervoltage fault during suspend latches with code 2.
- R9: `pgood_valid` follows the synchronized supply status. While it is low, `pgood` is low.
- R10: `fault_code` encodes 0 = none, 1 = overcurrent and 2 = undervoltage. It keeps the first latched cause until cleared. If both faults qualify on the same edge, the code is 1.
- R11: A change of `en_lvl` reaches `pwm_en` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_cmp | input | 1 | Current-sense comparator: sense above output |
| uv_cmp | input | 1 | Feedback below the undervoltage level |
| ot_hot | input | 1 | Temperature above the rising limit |
| ot_cool | input | 1 | Temperature below the hysteresis release level |
| en_lvl | input | 1 | Enable above its threshold |
| por_ok | input | 1 | Supply above its power-on threshold |
| pwm_en | output | 1 | PWM may run |
| hs_gate_en | output | 1 | High-side gate drive enable |
| ls_gate_en | output | 1 | Low-side gate drive enable |
| pgood | output | 1 | Power-good |
| pgood_valid | output | 1 | Power-good is meaningful |
| fault_code | output | 2 | Cause of the latched fault |

## Verification
The hardest case to reach from the ports is an overcurrent and an undervoltage fault that qualify on the very same clock edge. The two filters have different lengths, so both inputs must be raised with an offset equal to the difference of their limits. The bench raises the overcurrent input first, waits exactly OC_LIM − UV_LIM cycles, then raises undervoltage, and expects cause code 1. The exact persistence boundary is reached the same way: the bench drives bursts of exactly the limit and one cycle more.

// File: rtl/psv_pkg.sv
`timescale 1ns/1ps
package psv_pkg;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_OC   = 2'd1,
        FC_UV   = 2'd2
    } fault_code_t;

    // synchronizer bit positions
    localparam int SB_OC   = 0;
    localparam int SB_UV   = 1;
    localparam int SB_HOT  = 2;
    localparam int SB_COOL = 3;
    localparam int SB_EN   = 4;
    localparam int SB_POR  = 5;
    localparam int N_SYNC  = 6;

    // persistence filter positions; lower index wins a tie
    localparam int FI_OC   = 0;
    localparam int FI_UV   = 1;
    localparam int N_FLT   = 2;

    function automatic int ns_to_cycles(longint clk_hz, longint dur_ns);
        return int'((dur_ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/psv_sync.sv
`timescale 1ns/1ps
module psv_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stab;
endmodule

// File: rtl/psv_persist.sv
`timescale 1ns/1ps
module psv_persist #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cond,
    output logic trip
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CMAX = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } per_st_t;

    per_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run || !cond)        st_d.cnt = '0;
        else if (st_q.cnt != CMAX) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // high on the edge where the condition is seen for the LIMIT+1-th time in a row
    assign trip = run && cond && (st_q.cnt == CMAX);
endmodule

// File: rtl/prot_supervisor.sv
`timescale 1ns/1ps
module prot_supervisor
    import psv_pkg::*;
#(
    parameter longint CLK_HZ = 50_000_000,
    parameter longint OC_NS  = 10_000,
    parameter longint UV_NS  = 2_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oc_cmp,
    input  logic       uv_cmp,
    input  logic       ot_hot,
    input  logic       ot_cool,
    input  logic       en_lvl,
    input  logic       por_ok,
    output logic       pwm_en,
    output logic       hs_gate_en,
    output logic       ls_gate_en,
    output logic       pgood,
    output logic       pgood_valid,
    output logic [1:0] fault_code
);
    localparam int OC_LIM = ns_to_cycles(CLK_HZ, OC_NS);
    localparam int UV_LIM = ns_to_cycles(CLK_HZ, UV_NS);

    logic [N_SYNC-1:0] raw_v, syn_v;
    logic [N_FLT-1:0]  cond_v, trip_v;
    logic oc_s, uv_s, hot_s, cool_s, en_s, por_s, active;

    assign raw_v[SB_OC]   = oc_cmp;
    assign raw_v[SB_UV]   = uv_cmp;
    assign raw_v[SB_HOT]  = ot_hot;
    assign raw_v[SB_COOL] = ot_cool;
    assign raw_v[SB_EN]   = en_lvl;
    assign raw_v[SB_POR]  = por_ok;

    psv_sync #(.W(N_SYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_v),
        .sync_o  (syn_v)
    );

    assign oc_s   = syn_v[SB_OC];
    assign uv_s   = syn_v[SB_UV];
    assign hot_s  = syn_v[SB_HOT];
    assign cool_s = syn_v[SB_COOL];
    assign en_s   = syn_v[SB_EN];
    assign por_s  = syn_v[SB_POR];
    assign active = en_s && por_s;

    assign cond_v[FI_OC] = oc_s;
    assign cond_v[FI_UV] = uv_s;

    for (genvar g = 0; g < N_FLT; g++) begin : g_flt
        psv_persist #(.LIMIT(g == FI_OC ? OC_LIM : UV_LIM)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (active),
            .cond  (cond_v[g]),
            .trip  (trip_v[g])
        );
    end

    typedef struct packed {
        logic        fault;
        fault_code_t code;
        logic        susp;
    } sup_st_t;

    sup_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.fault = 1'b0;
            st_d.code  = FC_NONE;
            st_d.susp  = 1'b0;
        end else begin
            if (!st_q.fault) begin
                if (trip_v[FI_OC]) begin
                    st_d.fault = 1'b1;
                    st_d.code  = FC_OC;
                end else if (trip_v[FI_UV]) begin
                    st_d.fault = 1'b1;
                    st_d.code  = FC_UV;
                end
            end
            if (hot_s)       st_d.susp = 1'b1;
            else if (cool_s) st_d.susp = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{fault: 1'b0, code: FC_NONE, susp: 1'b0};
        else        st_q <= st_d;
    end

    assign pwm_en      = active && !st_q.fault;
    assign hs_gate_en  = pwm_en && !st_q.susp;
    assign ls_gate_en  = pwm_en && !st_q.susp;
    assign pgood       = active && !st_q.fault;
    assign pgood_valid = por_s;
    assign fault_code  = st_q.code;
endmodule

// File: rtl/psv_checker.sv
`timescale 1ns/1ps
module psv_checker
    import psv_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       active,
    input logic       oc_s,
    input logic       uv_s,
    input logic       pwm_en,
    input logic       hs_gate_en,
    input logic       ls_gate_en,
    input logic       pgood,
    input logic       pgood_valid,
    input logic [1:0] fault_code
);
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != FC_NONE) |-> (!pwm_en && !pgood)); // R3
    AST_OC_PERSISTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_code) == FC_NONE && fault_code == FC_OC) |-> $past(oc_s)); // R1
    AST_UV_PERSISTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_code) == FC_NONE && fault_code == FC_UV) |-> $past(uv_s)); // R2
    AST_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (fault_code == FC_NONE)); // R4
    AST_HS_UNDER_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        hs_gate_en |-> pwm_en); // R6
    AST_LS_UNDER_PWM: assert property (@(posedge clk) disable iff (!rst_n)
        ls_gate_en |-> pwm_en); // R6
    AST_PG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood_valid |-> !pgood); // R9
    AST_CODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code != FC_NONE && active) |=> (fault_code == $past(fault_code))); // R10
endmodule

bind prot_supervisor psv_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (active),
    .oc_s        (oc_s),
    .uv_s        (uv_s),
    .pwm_en      (pwm_en),
    .hs_gate_en  (hs_gate_en),
    .ls_gate_en  (ls_gate_en),
    .pgood       (pgood),
    .pgood_valid (pgood_valid),
    .fault_code  (fault_code)
);

// File: tb/prot_supervisor_bench.sv
`timescale 1ns/1ps
module prot_supervisor_bench;
    // ceil(10us * 50MHz) and ceil(2us * 50MHz)
    localparam int OC_CYC = 500;
    localparam int UV_CYC = 100;
    localparam logic [4:0] ALL_ON  = 5'b11111; // {pwm,hs,ls,pg,valid}
    localparam logic [4:0] LATCHED = 5'b00001;
    localparam logic [4:0] SUSPEND = 5'b10011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_cmp = 0, uv_cmp = 0, ot_hot = 0, ot_cool = 0, en_lvl = 0, por_ok = 0;
    logic pwm_en, hs_gate_en, ls_gate_en, pgood, pgood_valid;
    logic [1:0] fault_code;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    prot_supervisor u_prot_supervisor (
        .clk(clk), .rst_n(rst_n), .oc_cmp(oc_cmp), .uv_cmp(uv_cmp),
        .ot_hot(ot_hot), .ot_cool(ot_cool), .en_lvl(en_lvl), .por_ok(por_ok),
        .pwm_en(pwm_en), .hs_gate_en(hs_gate_en), .ls_gate_en(ls_gate_en),
        .pgood(pgood), .pgood_valid(pgood_valid), .fault_code(fault_code)
    );

    function automatic logic [4:0] outs();
        return {pwm_en, hs_gate_en, ls_gate_en, pgood, pgood_valid};
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rearm();
        oc_cmp = 0; uv_cmp = 0; ot_hot = 0; ot_cool = 0;
        step(4);
        en_lvl = 0; step(4);
        en_lvl = 1; step(4);
    endtask

    task automatic t_reset();
        por_ok = 1; en_lvl = 1;
        step(3);
        check("R9 reset outputs", outs(), 0);
        check("R10 reset code", fault_code, 0);
        rst_n = 1;
        step(4);
        check("R9 after reset", outs(), ALL_ON);
    endtask

    task automatic t_latency();
        en_lvl = 0; step(4);
        check("R4 enable low", outs(), 5'b00001);
        en_lvl = 1; step(1);
        check("R11 one edge", pwm_en, 0);
        step(1);
        check("R11 two edges", pwm_en, 1);
        step(2);
    endtask

    task automatic t_oc();
        oc_cmp = 1; step(OC_CYC - 5); oc_cmp = 0; step(1);
        oc_cmp = 1; step(OC_CYC - 5); oc_cmp = 0; step(6);
        check("R1 restart on drop", fault_code, 0);
        oc_cmp = 1; step(OC_CYC); oc_cmp = 0; step(6);
        check("R1 exact limit no trip", fault_code, 0);
        check("R1 outputs on", outs(), ALL_ON);
        oc_cmp = 1; step(OC_CYC + 1); oc_cmp = 0; step(6);
        check("R1 limit+1 trips", fault_code, 1);
        check("R3 latched off", outs(), LATCHED);
        step(30);
        check("R3 stays latched", outs(), LATCHED);
        en_lvl = 0; step(4);
        check("R4 code cleared", fault_code, 0);
        en_lvl = 1; step(4);
        check("R4 resume", outs(), ALL_ON);
    endtask

    task automatic t_uv();
        uv_cmp = 1; step(UV_CYC); uv_cmp = 0; step(6);
        check("R2 exact limit no trip", fault_code, 0);
        uv_cmp = 1; step(UV_CYC + 1); uv_cmp = 0; step(6);
        check("R2 limit+1 trips", fault_code, 2);
        check("R3 uv latched off", outs(), LATCHED);
        por_ok = 0; step(4);
        check("R9 invalid", outs(), 0);
        check("R5 code cleared", fault_code, 0);
        por_ok = 1; step(4);
        check("R5 resume", outs(), ALL_ON);
    endtask

    task automatic t_thermal();
        ot_hot = 1; step(6);
        check("R6 suspend", outs(), SUSPEND);
        check("R6 no latch", fault_code, 0);
        ot_hot = 0; step(6);
        check("R7 held after hot falls", outs(), SUSPEND);
        ot_cool = 1; step(6);
        check("R7 cool resumes", outs(), ALL_ON);
        ot_cool = 0; ot_hot = 1; step(2); ot_hot = 0; step(6);
        check("R7 suspended again", outs(), SUSPEND);
        en_lvl = 0; step(4); en_lvl = 1; step(6);
        check("R7 enable clears suspend", outs(), ALL_ON);
    endtask

    task automatic t_uv_susp();
        ot_hot = 1; uv_cmp = 1;
        step(UV_CYC + 5); uv_cmp = 0; step(6);
        check("R8 uv in suspend", fault_code, 2);
        check("R8 latched off", outs(), LATCHED);
        rearm();
        check("R8 rearmed", outs(), ALL_ON);
    endtask

    task automatic t_order();
        oc_cmp = 1; step(OC_CYC - UV_CYC);
        uv_cmp = 1; step(UV_CYC + 5);
        oc_cmp = 0; uv_cmp = 0; step(6);
        check("R10 tie resolves to oc", fault_code, 1);
        rearm();
        uv_cmp = 1; step(UV_CYC + 5); uv_cmp = 0;
        oc_cmp = 1; step(OC_CYC + 5); oc_cmp = 0; step(6);
        check("R10 first cause kept", fault_code, 2);
        rearm();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_latency();
        t_oc();
        t_uv();
        t_thermal();
        t_uv_susp();
        t_order();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule